// File: doc/BRIEF.md
# Ordered Store Buffer with Fence Handling

This block sits between a simple in-order core and a single-ported data cache. Stores leave the core as soon as the buffer accepts them. They wait in a first-in first-out queue and are written to the cache one per cycle, in the order they arrived, whenever the cache port is not needed for a read. Loads search the queue first. When one or more queued stores target the load address, the newest of them supplies the data. When none does, the load reads the cache at once, even though older stores to other addresses are still waiting. Of all the orderings a program could expect, this store-then-load overtaking is the only one the block gives up.

Three kinds of fence request and a locked swap let software restore stricter ordering. A full fence stops later loads and stores until the queue is empty. A store fence stops later stores until the queue is empty. A load fence separates a load from the loads after it. The locked swap waits for an empty queue, then reads the old word and writes the new one in a single cache cycle. The cache write port has a grant input, so several buffers can share one cache model.

Top module: `tso_sbuf`

## Requirements
- R1: Buffered stores reach the cache write port strictly in acceptance order, at most one per cycle, whenever the queue is non-empty and the port is not used by a load read that cycle.
- R2: A load whose address matches one or more queued stores returns the data of the most recently accepted matching store. The cache is not read in that case.
- R3: A load whose address matches no queued store reads the cache in the cycle it is accepted, while older queued stores to other addresses stay unwritten.
- R4: An accepted load or swap produces `rsp_valid` with its data exactly one cycle later. Loads are answered in acceptance order. A store accepted in the same cycle as a load counts as younger than that load.
- R5: With DEPTH (default 8) entries occupied, `st_ready` is low and no store is accepted.
- R6: In a cycle where a load reads the cache, `mem_wr_valid` is low for queue drains.
- R7: Fence code 2'b00 (full) holds `ld_ready` and `st_ready` low from the cycle the fence is presented until the queue is empty. Requests presented in the same cycle as the fence count as later than it.
- R8: Fence code 2'b01 (store) holds `st_ready` low from the cycle it is presented until the queue is empty. `ld_ready` is not affected.
- R9: Fence code 2'b10 (load), presented in the cycle a load is accepted, holds `ld_ready` low for exactly the next cycle. Code 2'b11 has no effect.
- R10: A locked swap is accepted only when the queue is empty and the write grant is high. It returns the old cache word and writes the new word in its acceptance cycle. Loads and stores are held off while a swap is requested.
- R11: After reset the queue is empty, `st_ready` and `ld_ready` are high, and `rsp_valid` and `mem_wr_valid` are low.
- R12: Two buffers sharing one cache, each storing 1 to its own flag and then loading the other flag, can both read 0 without fences. With a full fence between the store and the load, at least one of them reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load accepted this cycle when high with ld_valid |
| ld_addr | input | AW | Load word address |
| rsp_valid | output | 1 | Load or swap response pulse |
| rsp_data | output | DW | Response data |
| fn_valid | input | 1 | Fence request, always accepted |
| fn_kind | input | 2 | Fence code: 00 full, 01 store, 10 load, 11 none |
| at_valid | input | 1 | Locked swap request |
| at_ready | output | 1 | Swap accepted this cycle |
| at_addr | input | AW | Swap address |
| at_data | input | DW | Word written by the swap |
| mem_rd_addr | output | AW | Cache read address |
| mem_rd_data | input | DW | Cache read data, same cycle |
| mem_wr_valid | output | 1 | Cache write request |
| mem_wr_ready | input | 1 | Cache write grant |
| mem_wr_addr | output | AW | Cache write address |
| mem_wr_data | output | DW | Cache write data |

## Verification
The bench builds two instances with the default depth of 8, a 4-bit address and 16-bit data. The narrow address space keeps random loads colliding with queued stores, so forwarding of the youngest entry is exercised often. The full 8-entry depth is reached by withholding the write grant. Sharing one cache model between the two instances makes the flag-exchange test possible, so it can show both the weakened ordering and its repair by fences.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;

  typedef enum logic [1:0] {
    FN_FULL  = 2'b00,
    FN_STORE = 2'b01,
    FN_LOAD  = 2'b10,
    FN_NONE  = 2'b11
  } fence_kind_e;

  // Physical slot holding the entry that is `age` positions younger than the head.
  function automatic int unsigned slot_of(input int unsigned head,
                                          input int unsigned age,
                                          input int unsigned depth);
    return (head + age) % depth;
  endfunction

  // Pointer advance with wrap at an arbitrary depth.
  function automatic int unsigned ptr_next(input int unsigned ptr,
                                           input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/tso_sb_fifo.sv
module tso_sb_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [AW-1:0]                 push_addr,
  input  logic [DW-1:0]                 push_data,
  input  logic                          pop,
  output logic [CW-1:0]                 count,
  output logic [AW-1:0]                 head_addr,
  output logic [DW-1:0]                 head_data,
  output logic [DEPTH-1:0]              age_vld,
  output logic [DEPTH-1:0][AW-1:0]      age_addr,
  output logic [DEPTH-1:0][DW-1:0]      age_data
);
  import tso_sb_pkg::*;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) begin
        addr_q[tail_q] <= push_addr;
        data_q[tail_q] <= push_data;
        tail_q         <= PW'(ptr_next(32'(tail_q), DEPTH));
      end
      if (pop) head_q <= PW'(ptr_next(32'(head_q), DEPTH));
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end

  assign count     = count_q;
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];

  // Entries presented oldest first, so the forwarding search can favour the youngest.
  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [PW-1:0] slot;
    assign slot        = PW'(slot_of(32'(head_q), g, DEPTH));
    assign age_vld[g]  = (CW'(g) < count_q);
    assign age_addr[g] = addr_q[slot];
    assign age_data[g] = data_q[slot];
  end

endmodule

// File: rtl/tso_sb_fwd.sv
module tso_sb_fwd #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic [DEPTH-1:0]         age_vld,
  input  logic [DEPTH-1:0][AW-1:0] age_addr,
  input  logic [DEPTH-1:0][DW-1:0] age_data,
  input  logic [AW-1:0]            look_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);
  // Scan oldest to youngest; a later match overrides, leaving the youngest.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (age_vld[i] && age_addr[i] == look_addr) begin
        hit      = 1'b1;
        hit_data = age_data[i];
      end
    end
  end

endmodule

// File: rtl/tso_sbuf.sv
module tso_sbuf #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic          fn_valid,
  input  logic [1:0]    fn_kind,
  input  logic          at_valid,
  output logic          at_ready,
  input  logic [AW-1:0] at_addr,
  input  logic [DW-1:0] at_data,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data
);
  import tso_sb_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic          st_fire, ld_fire, at_fire, drain_fire, ld_cache_rd;
  logic          q_empty, q_full, fwd_hit;
  logic [CW-1:0] q_count;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, fwd_data;
  logic [DEPTH-1:0]         age_vld;
  logic [DEPTH-1:0][AW-1:0] age_addr;
  logic [DEPTH-1:0][DW-1:0] age_data;

  logic full_pend_q, st_pend_q, ld_pend_q;
  logic fn_full_now, fn_st_now, fn_ld_now;
  logic full_hold, st_hold, drain_req;

  tso_sb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk, .rst_n,
    .push(st_fire), .push_addr(st_addr), .push_data(st_data),
    .pop(drain_fire),
    .count(q_count), .head_addr, .head_data,
    .age_vld, .age_addr, .age_data
  );

  tso_sb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .age_vld, .age_addr, .age_data,
    .look_addr(ld_addr), .hit(fwd_hit), .hit_data(fwd_data)
  );

  assign q_empty = (q_count == '0);
  assign q_full  = (q_count == CW'(DEPTH));

  assign fn_full_now = fn_valid && fn_kind == FN_FULL;
  assign fn_st_now   = fn_valid && fn_kind == FN_STORE;
  assign fn_ld_now   = fn_valid && fn_kind == FN_LOAD;

  // A fence blocks from the cycle it is presented until the queue is empty.
  assign full_hold = (full_pend_q || fn_full_now) && !q_empty;
  assign st_hold   = (st_pend_q   || fn_st_now)   && !q_empty;

  assign ld_ready = !full_hold && !ld_pend_q && !at_valid;
  assign st_ready = !q_full && !full_hold && !st_hold && !at_valid;
  assign at_ready = q_empty && mem_wr_ready;

  assign st_fire = st_valid && st_ready;
  assign ld_fire = ld_valid && ld_ready;
  assign at_fire = at_valid && at_ready;

  // Single cache port: a load that misses the queue takes it for reading.
  assign ld_cache_rd = ld_fire && !fwd_hit;
  assign drain_req   = !q_empty && !ld_cache_rd;
  assign drain_fire  = drain_req && mem_wr_ready;

  assign mem_rd_addr  = at_valid ? at_addr : ld_addr;
  assign mem_wr_valid = drain_req || (at_valid && q_empty);
  assign mem_wr_addr  = q_empty ? at_addr : head_addr;
  assign mem_wr_data  = q_empty ? at_data : head_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_pend_q <= 1'b0;
      st_pend_q   <= 1'b0;
      ld_pend_q   <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      full_pend_q <= full_hold;
      st_pend_q   <= st_hold;
      ld_pend_q   <= fn_ld_now && ld_fire;
      rsp_valid   <= ld_fire || at_fire;
      if (ld_fire)      rsp_data <= fwd_hit ? fwd_data : mem_rd_data;
      else if (at_fire) rsp_data <= mem_rd_data;
    end
  end

endmodule

// File: rtl/tso_sbuf_chk.sv
module tso_sbuf_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] q_count,
  input logic          st_fire,
  input logic          ld_fire,
  input logic          at_fire,
  input logic          ld_cache_rd,
  input logic          drain_fire,
  input logic          fn_valid,
  input logic [1:0]    fn_kind,
  input logic          rsp_valid
);
  logic full_seen_q;
  logic fn_full;
  assign fn_full = fn_valid && fn_kind == 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) full_seen_q <= 1'b0;
    else        full_seen_q <= (full_seen_q || fn_full) && q_count != '0;
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_count == CW'(DEPTH) |-> !st_fire);

  assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_cache_rd && drain_fire));

  assert_full_fence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_seen_q || fn_full) && q_count != '0 |-> !ld_fire && !st_fire);

  assert_rsp_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire || at_fire) |=> rsp_valid);

  assert_no_stray_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_fire || at_fire) |=> !rsp_valid);

  assert_swap_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    at_fire |-> q_count == '0);

  assert_drain_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    drain_fire && !st_fire |=> q_count == $past(q_count) - CW'(1));

endmodule

bind tso_sbuf tso_sbuf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_count(q_count),
  .st_fire(st_fire), .ld_fire(ld_fire), .at_fire(at_fire),
  .ld_cache_rd(ld_cache_rd), .drain_fire(drain_fire),
  .fn_valid(fn_valid), .fn_kind(fn_kind), .rsp_valid(rsp_valid)
);

// File: tb/tso_sbuf_tb.sv
module tso_sbuf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b1;
  logic hold_a = 1'b0;

  logic st_v_a = 0, st_r_a, ld_v_a = 0, ld_r_a, rsp_v_a, fn_v_a = 0, at_v_a = 0, at_r_a;
  logic [AW-1:0] st_ad_a = '0, ld_ad_a = '0, at_ad_a = '0, rd_ad_a, wa_a;
  logic [DW-1:0] st_dt_a = '0, at_dt_a = '0, rsp_d_a, rd_d_a, wd_a;
  logic [1:0] fn_k_a = 2'b11;
  logic wv_a, wr_a;

  logic st_v_b = 0, st_r_b, ld_v_b = 0, ld_r_b, rsp_v_b, fn_v_b = 0, at_r_b;
  logic [AW-1:0] st_ad_b = '0, ld_ad_b = '0, rd_ad_b, wa_b;
  logic [DW-1:0] st_dt_b = '0, rsp_d_b, rd_d_b, wd_b;
  logic [1:0] fn_k_b = 2'b11;
  logic wv_b, wr_b;

  logic [DW-1:0] mem [16];
  assign wr_a   = !hold_a;
  assign wr_b   = !wv_a;
  assign rd_d_a = mem[rd_ad_a];
  assign rd_d_b = mem[rd_ad_b];

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      if (wv_a && wr_a) mem[wa_a] <= wd_a;
      if (wv_b && wr_b) mem[wa_b] <= wd_b;
    end
  end

  tso_sbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk, .rst_n,
    .st_valid(st_v_a), .st_ready(st_r_a), .st_addr(st_ad_a), .st_data(st_dt_a),
    .ld_valid(ld_v_a), .ld_ready(ld_r_a), .ld_addr(ld_ad_a),
    .rsp_valid(rsp_v_a), .rsp_data(rsp_d_a),
    .fn_valid(fn_v_a), .fn_kind(fn_k_a),
    .at_valid(at_v_a), .at_ready(at_r_a), .at_addr(at_ad_a), .at_data(at_dt_a),
    .mem_rd_addr(rd_ad_a), .mem_rd_data(rd_d_a),
    .mem_wr_valid(wv_a), .mem_wr_ready(wr_a), .mem_wr_addr(wa_a), .mem_wr_data(wd_a)
  );

  tso_sbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_peer (
    .clk, .rst_n,
    .st_valid(st_v_b), .st_ready(st_r_b), .st_addr(st_ad_b), .st_data(st_dt_b),
    .ld_valid(ld_v_b), .ld_ready(ld_r_b), .ld_addr(ld_ad_b),
    .rsp_valid(rsp_v_b), .rsp_data(rsp_d_b),
    .fn_valid(fn_v_b), .fn_kind(fn_k_b),
    .at_valid(1'b0), .at_ready(at_r_b), .at_addr('0), .at_data('0),
    .mem_rd_addr(rd_ad_b), .mem_rd_data(rd_d_b),
    .mem_wr_valid(wv_b), .mem_wr_ready(wr_b), .mem_wr_addr(wa_b), .mem_wr_data(wd_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] po [16];
  logic [AW-1:0] qa [64];
  logic [DW-1:0] qd [64];
  int qh = 0, qt = 0;
  bit last_af = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_a();
    st_v_a = 0; ld_v_a = 0; fn_v_a = 0; at_v_a = 0; fn_k_a = 2'b11;
  endtask

  task automatic idle_b();
    st_v_b = 0; ld_v_b = 0; fn_v_b = 0; fn_k_b = 2'b11;
  endtask

  // Called just after a falling edge with core A inputs set; returns at the next falling edge.
  task automatic step();
    bit wf, lf, af, sf;
    logic [DW-1:0] exp;
    exp = '0;
    #2;
    wf = wv_a && wr_a; lf = ld_v_a && ld_r_a; af = at_v_a && at_r_a; sf = st_v_a && st_r_a;
    if (wf && !af) begin
      chk(qh != qt && wa_a == qa[qh % 64] && wd_a == qd[qh % 64],
          "R1 drain order", longint'(wd_a), longint'(qd[qh % 64]));
      qh++;
    end
    if (lf) exp = po[ld_ad_a];
    if (af) begin exp = po[at_ad_a]; po[at_ad_a] = at_dt_a; end
    if (sf) begin qa[qt % 64] = st_ad_a; qd[qt % 64] = st_dt_a; qt++; po[st_ad_a] = st_dt_a; end
    last_af = af;
    @(posedge clk); #2;
    if (lf || af) chk(rsp_v_a && rsp_d_a == exp, "R2 R3 R4 load data", longint'(rsp_d_a), longint'(exp));
    else          chk(!rsp_v_a, "R4 no response", longint'(rsp_v_a), 0);
    @(negedge clk);
  endtask

  task automatic drain_all();
    idle_a(); hold_a = 0;
    for (int k = 0; k < 40 && qh != qt; k++) step();
  endtask

  task automatic dekker(input bit use_fence, output logic [DW-1:0] ra,
                        output logic [DW-1:0] rb, output bit got);
    bit ga, gb;
    ga = 0; gb = 0; ra = '1; rb = '1;
    idle_a(); idle_b(); clr = 1; @(negedge clk); clr = 0;
    st_v_a = 1; st_ad_a = 0; st_dt_a = 1;
    st_v_b = 1; st_ad_b = 1; st_dt_b = 1;
    @(negedge clk);
    st_v_a = 0; st_v_b = 0;
    ld_v_a = 1; ld_ad_a = 1; ld_v_b = 1; ld_ad_b = 0;
    fn_v_a = use_fence; fn_k_a = 2'b00; fn_v_b = use_fence; fn_k_b = 2'b00;
    for (int k = 0; k < 30 && !(ga && gb); k++) begin
      @(posedge clk); #2;
      fn_v_a = 0; fn_v_b = 0;
      if (rsp_v_a) begin ra = rsp_d_a; ga = 1; ld_v_a = 0; end
      if (rsp_v_b) begin rb = rsp_d_b; gb = 1; ld_v_b = 0; end
    end
    got = ga && gb;
    idle_a(); idle_b();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] ra, rb;
    bit got;
    void'($urandom(32'd7));
    for (int i = 0; i < 16; i++) po[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1; clr = 0;
    #2;
    // R11: reset state
    chk(st_r_a && ld_r_a, "R11 ready after reset", longint'({st_r_a, ld_r_a}), 3);
    chk(!rsp_v_a && !wv_a, "R11 idle after reset", longint'({rsp_v_a, wv_a}), 0);
    @(negedge clk);

    // R5: fill all entries with drains withheld
    hold_a = 1;
    for (int i = 0; i < DEPTH; i++) begin
      idle_a(); st_v_a = 1; st_ad_a = AW'(i % 4); st_dt_a = DW'(100 + i); step();
    end
    idle_a(); st_v_a = 1; st_ad_a = 0; st_dt_a = 200; #2;
    chk(!st_r_a, "R5 full stalls store", longint'(st_r_a), 0);
    st_v_a = 0; @(negedge clk);

    // R2: youngest of two matching entries (addr 1 holds 101 then 105)
    ld_v_a = 1; ld_ad_a = 1; step();
    chk(rsp_d_a == 105, "R2 youngest forward", longint'(rsp_d_a), 105);

    // R3: miss passes older stores; cache still stale at addr 1
    ld_ad_a = 9; step();
    chk(rsp_d_a == 0, "R3 bypass read", longint'(rsp_d_a), 0);
    chk(mem[1] == 0, "R3 older store unwritten", longint'(mem[1]), 0);

    // R6: load reading the cache blocks the drain that cycle
    hold_a = 0; ld_v_a = 1; ld_ad_a = 9; #2;
    chk(!wv_a, "R6 port busy with read", longint'(wv_a), 0);
    step();
    drain_all();
    for (int i = 0; i < 4; i++) chk(mem[i] == po[i], "R1 final contents", longint'(mem[i]), longint'(po[i]));

    // R7: full fence
    hold_a = 1; idle_a(); st_v_a = 1; st_ad_a = 2; st_dt_a = 7; step();
    idle_a(); fn_v_a = 1; fn_k_a = 2'b00; ld_v_a = 1; ld_ad_a = 5; st_v_a = 1; st_ad_a = 3; st_dt_a = 8; #2;
    chk(!ld_r_a && !st_r_a, "R7 same-cycle block", longint'({ld_r_a, st_r_a}), 0);
    step();
    fn_v_a = 0; st_v_a = 0; #2;
    chk(!ld_r_a, "R7 pending block", longint'(ld_r_a), 0);
    step();
    hold_a = 0; step();
    #2; chk(ld_r_a, "R7 released when empty", longint'(ld_r_a), 1);
    step(); idle_a();

    // R8: store fence
    hold_a = 1; st_v_a = 1; st_ad_a = 3; st_dt_a = 9; step();
    idle_a(); fn_v_a = 1; fn_k_a = 2'b01; st_v_a = 1; st_ad_a = 3; st_dt_a = 10; ld_v_a = 1; ld_ad_a = 2; #2;
    chk(!st_r_a && ld_r_a, "R8 stores only blocked", longint'({st_r_a, ld_r_a}), 1);
    step();
    fn_v_a = 0; ld_v_a = 0; #2;
    chk(!st_r_a, "R8 pending block", longint'(st_r_a), 0);
    step();
    hold_a = 0; step();
    #2; chk(st_r_a, "R8 released when empty", longint'(st_r_a), 1);
    step(); drain_all();

    // R9: load fence with a load
    ld_v_a = 1; ld_ad_a = 2; fn_v_a = 1; fn_k_a = 2'b10; step();
    fn_v_a = 0; #2;
    chk(!ld_r_a, "R9 one-cycle hold", longint'(ld_r_a), 0);
    step();
    #2; chk(ld_r_a, "R9 hold ends", longint'(ld_r_a), 1);
    fn_v_a = 1; fn_k_a = 2'b11; step();
    fn_v_a = 0; #2;
    chk(ld_r_a, "R9 code 11 no effect", longint'(ld_r_a), 1);
    step(); idle_a();

    // R10: locked swap
    hold_a = 1; st_v_a = 1; st_ad_a = 0; st_dt_a = 11; step();
    idle_a(); at_v_a = 1; at_ad_a = 0; at_dt_a = 22; ld_v_a = 1; ld_ad_a = 4; #2;
    chk(!at_r_a && !ld_r_a, "R10 waits for empty", longint'({at_r_a, ld_r_a}), 0);
    step();
    hold_a = 0;
    for (int k = 0; k < 6 && !last_af; k++) step();
    chk(last_af, "R10 swap accepted", longint'(last_af), 1);
    idle_a(); step();
    chk(mem[0] == 22, "R10 swap wrote", longint'(mem[0]), 22);

    // Random mix against the program-order model
    for (int n = 0; n < 600; n++) begin
      idle_a();
      hold_a  = ($urandom % 5) == 0;
      st_v_a  = ($urandom % 100) < 40; st_ad_a = AW'($urandom % 4); st_dt_a = DW'($urandom);
      ld_v_a  = ($urandom % 100) < 40; ld_ad_a = AW'($urandom % 5);
      fn_v_a  = ($urandom % 100) < 10; fn_k_a = 2'($urandom);
      at_v_a  = ($urandom % 100) < 4;  at_ad_a = AW'($urandom % 4); at_dt_a = DW'($urandom);
      step();
    end
    drain_all();
    for (int i = 0; i < 5; i++) chk(mem[i] == po[i], "R1 random final", longint'(mem[i]), longint'(po[i]));

    // R12: shared-cache flag exchange
    dekker(1'b0, ra, rb, got);
    chk(got && ra == 0 && rb == 0, "R12 both zero without fence", longint'({ra, rb}), 0);
    dekker(1'b1, ra, rb, got);
    chk(got && !(ra == 0 && rb == 0), "R12 fence forbids both zero", longint'({ra, rb}), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule